// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block chooses where each of the two execute-stage operands of a five-stage in-order pipeline comes from. It compares the two source register numbers of the instruction now in execute against the destination register numbers of the two older instructions still in flight, the one in the memory stage and the one in writeback. A comparison counts only when that older instruction actually writes a register. From the result it drives a 2-bit select per operand and steers the matching data word into the operand.

The selects and the steered operands are purely combinational. There is no register inside and no added latency. The block sits between the register-file read ports and the ALU inputs. A producer three or more stages ahead needs no bypass. The register file writes in the first half of a cycle and reads in the second, so its read data is already current.

Top module: `fwd_unit`

## Requirements
- R1: When an operand's source register equals the memory-stage destination and the memory-stage write enable is 1, its select is 2'b10 and the operand equals the memory-stage ALU result.
- R2: When an operand's source register equals the writeback destination, the writeback write enable is 1, and the memory stage does not match with its enable set, the select is 2'b01 and the operand equals the writeback result.
- R3: When both later stages match the same source with their enables set, the memory stage wins: the select is 2'b10. A chain of three dependent updates to one register therefore reads the newest value.
- R4: A stage whose write enable is 0 never supplies an operand, even if its destination register matches.
- R5: When no enabled stage matches, the select is 2'b00 and the operand equals the register-file read data for that operand.
- R6: Operand A and operand B are decided independently. A match on one never changes the select or the value of the other.
- R7: Selects and operands follow their inputs in the same cycle, with no clock edge in between.
- R8: The select value 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_AW (4) | First source register number of the execute-stage instruction |
| ex_src_b | input | REG_AW (4) | Second source register number of the execute-stage instruction |
| mem_dst | input | REG_AW (4) | Destination register of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | REG_AW (4) | Destination register of the writeback-stage instruction |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| rf_data_a | input | DATA_W (32) | Register-file read data for operand A |
| rf_data_b | input | DATA_W (32) | Register-file read data for operand B |
| mem_alu_result | input | DATA_W (32) | ALU result held in the memory stage |
| wb_result | input | DATA_W (32) | Result word in the writeback stage |
| sel_a | output | 2 | Source select for operand A (00 file, 01 writeback, 10 memory) |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | DATA_W (32) | Steered operand A |
| opnd_b | output | DATA_W (32) | Steered operand B |

## Verification
Every select and operand is due in the same cycle its inputs change, with zero register stages. The bench applies a new input set shortly after each falling clock edge. It compares all four outputs a fixed 1 ns later, well before the next rising edge, so the results have settled and stay unrelated to clock-edge ordering. The expected values come from a behavioural priority model in the bench. Directed cases cover the three-deep dependent chain and disabled stages with matching registers. A long run of random inputs then follows, drawn from a narrow register range so that matches are frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int NUM_OPND = 2;

    typedef enum logic [1:0] {
        SRC_FILE = 2'b00,
        SRC_WB   = 2'b01,
        SRC_MEM  = 2'b10
    } fwd_sel_e;

    // Youngest producer first: memory stage before writeback.
    function automatic fwd_sel_e pick_source(input logic hit_mem, input logic hit_wb);
        if (hit_mem)
            return SRC_MEM;
        else if (hit_wb)
            return SRC_WB;
        else
            return SRC_FILE;
    endfunction

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = 4
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic              wr_en,
    output logic              hit
);
    always_comb begin
        hit = wr_en && (src == dst);
    end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import fwd_pkg::*;
(
    input  logic     hit_mem,
    input  logic     hit_wb,
    output fwd_sel_e sel
);
    always_comb begin
        sel = pick_source(hit_mem, hit_wb);
    end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] file_data,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        unique case (sel)
            SRC_MEM: dout = mem_data;
            SRC_WB:  dout = wb_data;
            default: dout = file_data;
        endcase
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 4,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr_en,
    input  logic [DATA_W-1:0] rf_data_a,
    input  logic [DATA_W-1:0] rf_data_b,
    input  logic [DATA_W-1:0] mem_alu_result,
    input  logic [DATA_W-1:0] wb_result,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    logic [REG_AW-1:0] src_vec  [NUM_OPND];
    logic [DATA_W-1:0] file_vec [NUM_OPND];
    logic [DATA_W-1:0] out_vec  [NUM_OPND];
    fwd_sel_e          sel_vec  [NUM_OPND];

    assign src_vec[0]  = ex_src_a;
    assign src_vec[1]  = ex_src_b;
    assign file_vec[0] = rf_data_a;
    assign file_vec[1] = rf_data_b;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        logic hit_mem;
        logic hit_wb;

        fwd_match #(.REG_AW(REG_AW)) u_match_mem (
            .src   (src_vec[g]),
            .dst   (mem_dst),
            .wr_en (mem_wr_en),
            .hit   (hit_mem)
        );

        fwd_match #(.REG_AW(REG_AW)) u_match_wb (
            .src   (src_vec[g]),
            .dst   (wb_dst),
            .wr_en (wb_wr_en),
            .hit   (hit_wb)
        );

        fwd_prio u_prio (
            .hit_mem (hit_mem),
            .hit_wb  (hit_wb),
            .sel     (sel_vec[g])
        );

        fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel       (sel_vec[g]),
            .file_data (file_vec[g]),
            .wb_data   (wb_result),
            .mem_data  (mem_alu_result),
            .dout      (out_vec[g])
        );
    end

    assign sel_a  = sel_vec[0];
    assign sel_b  = sel_vec[1];
    assign opnd_a = out_vec[0];
    assign opnd_b = out_vec[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_AW = 4,
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] ex_src_a,
    input  logic [REG_AW-1:0] ex_src_b,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wr_en,
    input  logic [REG_AW-1:0] wb_dst,
    input  logic              wb_wr_en,
    input  logic [DATA_W-1:0] rf_data_a,
    input  logic [DATA_W-1:0] rf_data_b,
    input  logic [DATA_W-1:0] mem_alu_result,
    input  logic [DATA_W-1:0] wb_result,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b
);
    logic known;
    always_comb begin
        known = !$isunknown({ex_src_a, ex_src_b, mem_dst, mem_wr_en, wb_dst, wb_wr_en,
                             rf_data_a, rf_data_b, mem_alu_result, wb_result});
    end

    always_comb begin
        if (known) begin
            // R1, R3: an enabled memory-stage match always takes the operand
            p_mem_bypass_a_r1: assert (!(mem_wr_en && ex_src_a == mem_dst) ||
                                       (sel_a == 2'b10 && opnd_a == mem_alu_result))
                else $error("operand A missed memory bypass");
            p_mem_bypass_b_r1: assert (!(mem_wr_en && ex_src_b == mem_dst) ||
                                       (sel_b == 2'b10 && opnd_b == mem_alu_result))
                else $error("operand B missed memory bypass");
            // R2: writeback supplies only when memory does not
            p_wb_bypass_a_r2: assert (!(wb_wr_en && ex_src_a == wb_dst &&
                                        !(mem_wr_en && ex_src_a == mem_dst)) ||
                                      (sel_a == 2'b01 && opnd_a == wb_result))
                else $error("operand A missed writeback bypass");
            // R4, R5: nothing enabled and matching means register-file data
            p_file_a_r5: assert ((mem_wr_en && ex_src_a == mem_dst) ||
                                 (wb_wr_en && ex_src_a == wb_dst) ||
                                 (sel_a == 2'b00 && opnd_a == rf_data_a))
                else $error("operand A not from register file");
            p_file_b_r4: assert ((mem_wr_en && ex_src_b == mem_dst) ||
                                 (wb_wr_en && ex_src_b == wb_dst) ||
                                 (sel_b == 2'b00 && opnd_b == rf_data_b))
                else $error("operand B not from register file");
            // R8: the unused code never appears
            p_no_code3_r8: assert (sel_a != 2'b11 && sel_b != 2'b11)
                else $error("select 11 produced");
        end
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_fwd_unit_chk (.*);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
    localparam int REG_AW = 4;
    localparam int DATA_W = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [REG_AW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
    logic              mem_wr_en, wb_wr_en;
    logic [DATA_W-1:0] rf_data_a, rf_data_b, mem_alu_result, wb_result;
    logic [1:0]        sel_a, sel_b;
    logic [DATA_W-1:0] opnd_a, opnd_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    fwd_unit #(.REG_AW(REG_AW), .DATA_W(DATA_W)) i_fwd_unit (.*);

    // Behavioural reference: newest enabled producer wins.
    function automatic int ref_sel(int src);
        if (mem_wr_en && src == int'(mem_dst)) return 2;
        if (wb_wr_en && src == int'(wb_dst))   return 1;
        return 0;
    endfunction

    task automatic check_now(string req);
        int ea, eb;
        logic [DATA_W-1:0] va, vb;
        ea = ref_sel(int'(ex_src_a));
        eb = ref_sel(int'(ex_src_b));
        va = (ea == 2) ? mem_alu_result : (ea == 1) ? wb_result : rf_data_a;
        vb = (eb == 2) ? mem_alu_result : (eb == 1) ? wb_result : rf_data_b;
        n_tests++;
        if (int'(sel_a) != ea || opnd_a != va) begin
            n_fail++;
            $display("FAIL %s operand A: sel=%0d data=%h expected sel=%0d data=%h",
                     req, sel_a, opnd_a, ea, va);
        end
        n_tests++;
        if (int'(sel_b) != eb || opnd_b != vb) begin
            n_fail++;
            $display("FAIL %s operand B: sel=%0d data=%h expected sel=%0d data=%h",
                     req, sel_b, opnd_b, eb, vb);
        end
    endtask

    task automatic apply(input int sa, input int sb, input int md, input bit me,
                         input int wd, input bit we, string req);
        @(negedge clk);
        ex_src_a  = REG_AW'(sa);
        ex_src_b  = REG_AW'(sb);
        mem_dst   = REG_AW'(md);
        mem_wr_en = me;
        wb_dst    = REG_AW'(wd);
        wb_wr_en  = we;
        #1;
        check_now(req);
    endtask

    initial begin
        ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
        mem_wr_en = 1'b0; wb_wr_en = 1'b0;
        rf_data_a = 32'hAAAA_0001; rf_data_b = 32'hBBBB_0002;
        mem_alu_result = 32'h3333_0003; wb_result = 32'h4444_0004;

        apply(1, 2, 3, 1, 4, 1, "R5 idle no match");
        apply(3, 2, 3, 1, 4, 1, "R1 mem to A");
        apply(2, 3, 3, 1, 4, 1, "R1 mem to B, R6 A untouched");
        apply(4, 2, 3, 1, 4, 1, "R2 wb to A");
        apply(7, 7, 7, 1, 7, 1, "R3 both match, mem wins");
        // R3 three dependent updates to r1: third sees mem producer
        apply(1, 2, 9, 0, 9, 0, "R3 chain step 1");
        apply(1, 3, 1, 1, 9, 0, "R3 chain step 2");
        apply(1, 4, 1, 1, 1, 1, "R3 chain step 3");
        apply(5, 6, 5, 0, 6, 0, "R4 disabled matches ignored");
        apply(5, 5, 5, 0, 5, 1, "R4 mem disabled, wb supplies");
        apply(8, 9, 9, 1, 8, 1, "R6 A from wb B from mem");
        // R7: data change alone reaches operand without a clock edge
        @(negedge clk);
        ex_src_a = 4'd3; mem_dst = 4'd3; mem_wr_en = 1'b1;
        #0.5;
        mem_alu_result = 32'hDEAD_BEEF;
        #0.5;
        check_now("R7 same-cycle update");

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            ex_src_a  = REG_AW'($urandom_range(0, 3));
            ex_src_b  = REG_AW'($urandom_range(0, 3));
            mem_dst   = REG_AW'($urandom_range(0, 3));
            wb_dst    = REG_AW'($urandom_range(0, 3));
            mem_wr_en = 1'($urandom_range(0, 1));
            wb_wr_en  = 1'($urandom_range(0, 1));
            rf_data_a = $urandom; rf_data_b = $urandom;
            mem_alu_result = $urandom; wb_result = $urandom;
            #1;
            check_now("R8 random");
            n_tests++;
            if (sel_a == 2'b11 || sel_b == 2'b11) begin
                n_fail++;
                $display("FAIL R8 code 11: sel_a=%0d sel_b=%0d expected none equal 3", sel_a, sel_b);
            end
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: run did not end, expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule